// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block drives the memory side of a disk DMA channel. Software places a table of 8-byte region descriptors in memory, gives the block a pointer to the table, picks a direction and raises a run bit. The block then fetches each descriptor over a request/grant memory port. It issues one dword request per grant for every dword of the region the descriptor names, with per-lane byte enables. After it has moved the region whose descriptor carries the last-entry flag, it drops its busy status.

Each descriptor has two dwords. The first holds the region start address, which is always an even value. The second holds an even byte count and a last-entry flag. When the engine moves data from memory to the disk, it reads whole dwords and runs on to the next line boundary, so the line buffer can fill. The byte count of each region is reported separately so that only the programmed amount reaches the drive. When the engine moves data into memory, it writes only the valid half-words, and the byte enables trim the first and last dwords. Dropping the run bit stops the engine at once. Software uses this when the table describes more data than the drive transfer needs.

Top module: `sgdma_engine`

## Requirements
- R1: Reset leaves busy, mreq and rgn_load low. A low-to-high change of run while idle sets busy on the next clock edge, and the first request is then a descriptor fetch (mdesc=1) at tbl_ptr with bits 2:0 cleared. dir_wr is sampled at that same edge (1 = write into memory, 0 = read from memory).
- R2: Each descriptor is fetched as two reads with mdesc=1, mwe=0 and mbe=4'hF: first at the entry pointer, then at pointer+4. The pointer moves by 8 per entry.
- R3: Descriptor decode. Word 0 bits 31:1 give the region base, and bit 0 is treated as zero. Word 1 bits 15:1 give the byte count divided by two, and a zero field means 65536 bytes. Word 1 bit 31 is the last-entry flag. Word 1 bits 30:16 and bit 0 are ignored.
- R4: One cycle after the grant of the second descriptor word, rgn_load pulses for one cycle with rgn_bytes equal to the decoded byte count.
- R5: Read regions (mwe=0, mdesc=0) request consecutive dword addresses. They start at base with bits 1:0 cleared and use mbe=4'hF throughout, mbe bit i being byte lane maddr+i. The last dword is the one that ends on the first multiple of 64 at or above base+count.
- R6: Write regions (mwe=1) request consecutive dword addresses from base with bits 1:0 cleared up to the dword holding byte base+count-1. mbe[1:0] is cleared on a dword that starts below base (that is, the first dword when base bit 1 is set). mbe[3:2] is cleared on a dword whose upper half lies at or beyond base+count.
- R7: After the last dword of the region whose last-entry flag is set has been granted, busy drops on that clock edge. No further request is made until run goes low and high again.
- R8: After the last dword of a region without the flag, the next request is the fetch of the following entry, at the previous entry pointer plus 8.
- R9: When run is low at a clock edge, busy and mreq are low after that edge.
- R10: A request with no grant keeps mreq, maddr, mdesc and mwe unchanged into the next cycle while run stays high. A transfer completes only on a clock edge where mreq and mgnt are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start on rising edge, stop when low |
| dir_wr | input | 1 | Direction: 1 writes into memory, 0 reads from memory |
| tbl_ptr | input | ADDR_W | Descriptor table address |
| busy | output | 1 | Engine active |
| mreq | output | 1 | Memory request |
| mdesc | output | 1 | Current request is a descriptor fetch |
| mwe | output | 1 | Current request is a memory write |
| maddr | output | ADDR_W | Dword request address |
| mbe | output | 4 | Byte lane enables, active high |
| mgnt | input | 1 | Memory grant, completes the current request |
| mrdata | input | 32 | Read data, used for descriptor words |
| rgn_load | output | 1 | One-cycle pulse when a region is decoded |
| rgn_bytes | output | CNT_W+1 | Decoded byte count of that region |

## Verification
The hardest cases to reach are the byte-enable edges. A write region has a start offset of 2 within its dword, an end that falls mid-dword, or both at once in a single dword, and a read region ends one byte pair past a line boundary. The bench sweeps every even start offset across a full line. Each table holds eight regions, with counts on both sides of the dword and line boundaries, and runs in both directions with a pseudo-random grant. A single zero-count region in each direction covers the full 64 KiB span, and a stop in mid-region shows the abort.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DESC0 = 2'd1,
      ST_DESC1 = 2'd2,
      ST_MOVE  = 2'd3
   } sg_state_t;

   localparam int LANES      = 4;
   localparam int HALVES     = LANES / 2;
   localparam int ENTRY_SIZE = 8;
endpackage

// File: rtl/sgdma_desc_dec.sv
module sgdma_desc_dec #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic [31:0]       word0,
   input  logic [31:0]       word1,
   output logic [ADDR_W-1:0] base,
   output logic [CNT_W:0]    bytes,
   output logic              last
);
   logic [CNT_W-2:0] half_cnt;
   logic             unused_bits;

   assign half_cnt    = word1[CNT_W-1:1];
   assign base        = {word0[ADDR_W-1:1], 1'b0};
   assign bytes       = (half_cnt == '0) ? {1'b1, {CNT_W{1'b0}}}
                                         : {1'b0, half_cnt, 1'b0};
   assign last        = word1[31];
   assign unused_bits = ^{word0, word1};
endmodule

// File: rtl/sgdma_span.sv
module sgdma_span #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int LINE_BYTES = 64,
   parameter bit RD_ROUND   = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W:0]    bytes,
   input  logic              is_wr,
   output logic [ADDR_W-1:0] first,
   output logic [ADDR_W:0]   limit,
   output logic [ADDR_W:0]   stop
);
   localparam logic [ADDR_W:0] DW_MASK = (ADDR_W+1)'(3);

   logic [ADDR_W:0] wr_stop;
   logic [ADDR_W:0] rd_stop;

   assign first   = {base[ADDR_W-1:2], 2'b00};
   assign limit   = {1'b0, base} + (ADDR_W+1)'(bytes);
   assign wr_stop = (limit + DW_MASK) & ~DW_MASK;

   if (RD_ROUND) begin : g_line
      localparam logic [ADDR_W:0] LN_MASK = (ADDR_W+1)'(LINE_BYTES - 1);
      assign rd_stop = (limit + LN_MASK) & ~LN_MASK;
   end else begin : g_exact
      assign rd_stop = wr_stop;
   end

   assign stop = is_wr ? wr_stop : rd_stop;
endmodule

// File: rtl/sgdma_lane_en.sv
module sgdma_lane_en
   import sgdma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W:0]   limit,
   input  logic              is_wr,
   output logic [LANES-1:0]  be
);
   logic [HALVES-1:0] half_ok;
   logic [LANES-1:0]  wr_be;

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic [ADDR_W:0] lo_b;
      logic [ADDR_W:0] hi_b;
      assign lo_b       = {1'b0, cur} + (ADDR_W+1)'(2 * h);
      assign hi_b       = lo_b + (ADDR_W+1)'(2);
      assign half_ok[h] = (lo_b >= {1'b0, base}) && (hi_b <= limit);
      assign wr_be[2*h +: 2] = {2{half_ok[h]}};
   end

   assign be = is_wr ? wr_be : {LANES{1'b1}};
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
   import sgdma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int LINE_BYTES = 64,
   parameter bit RD_ROUND   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              dir_wr,
   input  logic [ADDR_W-1:0] tbl_ptr,
   output logic              busy,
   output logic              mreq,
   output logic              mdesc,
   output logic              mwe,
   output logic [ADDR_W-1:0] maddr,
   output logic [3:0]        mbe,
   input  logic              mgnt,
   input  logic [31:0]       mrdata,
   output logic              rgn_load,
   output logic [CNT_W:0]    rgn_bytes
);
   localparam logic [ADDR_W-1:0] ENTRY_STEP = ADDR_W'(ENTRY_SIZE);
   localparam logic [ADDR_W-1:0] ENTRY_MASK = ADDR_W'(ENTRY_SIZE - 1);
   localparam logic [ADDR_W:0]   DW_STEP    = (ADDR_W+1)'(LANES);

   if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr
      $error("sgdma_engine: ADDR_W must lie in 16..32");
   end
   if (CNT_W < 2 || CNT_W > 31 || CNT_W + 1 > ADDR_W) begin : g_bad_cnt
      $error("sgdma_engine: CNT_W out of range");
   end
   if (LINE_BYTES < LANES || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("sgdma_engine: LINE_BYTES must be a power of two of at least 4");
   end

   sg_state_t         state;
   logic              run_q;
   logic              wr_q;
   logic              eot_q;
   logic [ADDR_W-1:0] ptr;
   logic [ADDR_W-1:0] cur;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W:0]   limit_q;
   logic [ADDR_W:0]   stop_q;
   logic [31:0]       word0_q;

   logic [ADDR_W-1:0] dec_base;
   logic [CNT_W:0]    dec_bytes;
   logic              dec_last;
   logic [ADDR_W-1:0] sp_first;
   logic [ADDR_W:0]   sp_limit;
   logic [ADDR_W:0]   sp_stop;
   logic [3:0]        lane_be;
   logic              final_dw;

   sgdma_desc_dec #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
      .word0 (word0_q),
      .word1 (mrdata),
      .base  (dec_base),
      .bytes (dec_bytes),
      .last  (dec_last)
   );

   sgdma_span #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES),
                .RD_ROUND(RD_ROUND)) u_span (
      .base  (dec_base),
      .bytes (dec_bytes),
      .is_wr (wr_q),
      .first (sp_first),
      .limit (sp_limit),
      .stop  (sp_stop)
   );

   sgdma_lane_en #(.ADDR_W(ADDR_W)) u_lane (
      .cur   (cur),
      .base  (base_q),
      .limit (limit_q),
      .is_wr (wr_q),
      .be    (lane_be)
   );

   assign final_dw = ({1'b0, cur} + DW_STEP) >= stop_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         run_q     <= 1'b0;
         busy      <= 1'b0;
         wr_q      <= 1'b0;
         eot_q     <= 1'b0;
         ptr       <= '0;
         cur       <= '0;
         base_q    <= '0;
         limit_q   <= '0;
         stop_q    <= '0;
         word0_q   <= '0;
         rgn_load  <= 1'b0;
         rgn_bytes <= '0;
      end else begin
         run_q    <= run;
         rgn_load <= 1'b0;
         if (!run) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  if (!run_q) begin
                     state <= ST_DESC0;
                     busy  <= 1'b1;
                     ptr   <= tbl_ptr & ~ENTRY_MASK;
                     wr_q  <= dir_wr;
                  end
               end
               ST_DESC0: begin
                  if (mgnt) begin
                     word0_q <= mrdata;
                     state   <= ST_DESC1;
                  end
               end
               ST_DESC1: begin
                  if (mgnt) begin
                     base_q    <= dec_base;
                     eot_q     <= dec_last;
                     cur       <= sp_first;
                     limit_q   <= sp_limit;
                     stop_q    <= sp_stop;
                     rgn_load  <= 1'b1;
                     rgn_bytes <= dec_bytes;
                     ptr       <= ptr + ENTRY_STEP;
                     state     <= ST_MOVE;
                  end
               end
               ST_MOVE: begin
                  if (mgnt) begin
                     cur <= cur + ADDR_W'(LANES);
                     if (final_dw) begin
                        if (eot_q) begin
                           state <= ST_IDLE;
                           busy  <= 1'b0;
                        end else begin
                           state <= ST_DESC0;
                        end
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      mreq  = (state != ST_IDLE);
      mdesc = (state == ST_DESC0) || (state == ST_DESC1);
      mwe   = (state == ST_MOVE) && wr_q;
      unique case (state)
         ST_DESC0: maddr = ptr;
         ST_DESC1: maddr = {ptr[ADDR_W-1:3], 3'b100};
         default:  maddr = cur;
      endcase
      mbe = (state == ST_MOVE) ? lane_be : 4'hF;
   end
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              busy,
   input logic              mreq,
   input logic              mdesc,
   input logic              mwe,
   input logic [ADDR_W-1:0] maddr,
   input logic [3:0]        mbe,
   input logic              mgnt,
   input logic              rgn_load
);
   p_rd_full_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq && !mdesc && !mwe) |-> (mbe == 4'hF));

   p_dw_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mreq |-> (maddr[1:0] == 2'b00));

   p_desc_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq && mdesc) |-> (!mwe && mbe == 4'hF));

   p_wr_some_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq && mwe) |-> (mbe != 4'h0));

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mreq);

   p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!busy && !mreq));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mreq && !mgnt) |=> (mreq && $stable(maddr) && $stable(mdesc) && $stable(mwe)));

   p_load_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_load |=> !rgn_load);
endmodule

bind sgdma_engine sgdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .busy     (busy),
   .mreq     (mreq),
   .mdesc    (mdesc),
   .mwe      (mwe),
   .maddr    (maddr),
   .mbe      (mbe),
   .mgnt     (mgnt),
   .rgn_load (rgn_load)
);

// File: tb/sgdma_engine_bench.sv
module sgdma_engine_bench;
   localparam int CNT_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        dir_wr = 1'b0;
   logic [31:0] tbl_ptr = '0;
   logic        busy, mreq, mdesc, mwe, rgn_load;
   logic [31:0] maddr;
   logic [3:0]  mbe;
   logic        mgnt = 1'b0;
   logic [31:0] mrdata;
   logic [CNT_W:0] rgn_bytes;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] tbl_mem [16];
   logic [31:0] tbl_al;
   int          cnt_l [8];
   logic [37:0] expq [$];
   int          rgnq [$];
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   sgdma_engine u_sgdma_engine (
      .clk(clk), .rst_n(rst_n), .run(run), .dir_wr(dir_wr), .tbl_ptr(tbl_ptr),
      .busy(busy), .mreq(mreq), .mdesc(mdesc), .mwe(mwe), .maddr(maddr),
      .mbe(mbe), .mgnt(mgnt), .mrdata(mrdata), .rgn_load(rgn_load),
      .rgn_bytes(rgn_bytes)
   );

   always_comb begin
      logic [31:0] idx;
      idx = (maddr - tbl_al) >> 2;
      if (mdesc && idx < 16) mrdata = tbl_mem[idx[3:0]];
      else                   mrdata = 32'hDEAD_BEEF;
   end

   task automatic check(input bit ok, input string rq, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Pseudo-random grant, about three cycles in four.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         mgnt = |lfsr[1:0];
      end
   end

   // Transfer monitor.
   initial begin
      logic        stall_pend;
      logic [37:0] stall_v;
      logic [37:0] got;
      logic [37:0] exp;
      stall_pend = 1'b0;
      stall_v = '0;
      forever begin
         @(negedge clk);
         got = {mdesc, mwe, mbe, maddr};
         if (rst_n) begin
            if (stall_pend)
               check(mreq && got == stall_v, "R10 request held", {mreq, got}, {1'b1, stall_v});
            stall_pend = mreq && !mgnt && run;
            stall_v = got;
            if (rgn_load) begin
               if (rgnq.size() == 0) check(1'b0, "R4 unexpected rgn_load", rgn_bytes, 0);
               else begin
                  int e;
                  e = rgnq.pop_front();
                  check(rgn_bytes == e, "R3/R4 region byte count", rgn_bytes, e);
               end
            end
            if (mreq && mgnt) begin
               if (expq.size() == 0) check(1'b0, "R7 transfer after table end", got, 0);
               else begin
                  exp = expq.pop_front();
                  if (exp[37])      check(got == exp, "R2/R8 descriptor fetch", got, exp);
                  else if (exp[36]) check(got == exp, "R6 write dword", got, exp);
                  else              check(got == exp, "R5 read dword", got, exp);
               end
            end
         end
      end
   end

   // Fill table and expected streams. Region k sits at 0x100000 + k*0x400 + off.
   task automatic load_table(input bit wr, input int off, input int n, input logic [31:0] raw);
      tbl_ptr = raw;
      tbl_al  = raw & ~32'h7;
      dir_wr  = wr;
      for (int k = 0; k < n; k++) begin
         int b, c, e, a, s;
         logic lo, hi;
         b = 32'h0010_0000 + k * 32'h400 + off;
         tbl_mem[2*k]   = b | 1;
         tbl_mem[2*k+1] = (cnt_l[k] & 32'hFFFE) | 32'h2B5C_0001 | ((k == n - 1) ? 32'h8000_0000 : 0);
         expq.push_back({1'b1, 1'b0, 4'hF, tbl_al + 32'(8 * k)});
         expq.push_back({1'b1, 1'b0, 4'hF, tbl_al + 32'(8 * k + 4)});
         c = cnt_l[k];
         rgnq.push_back(c);
         e = b + c;
         a = b & ~3;
         if (!wr) begin
            s = ((e + 63) / 64) * 64;
            while (a < s) begin
               expq.push_back({1'b0, 1'b0, 4'hF, 32'(a)});
               a += 4;
            end
         end else begin
            while (a < e) begin
               lo = (a >= b) && (a + 2 <= e);
               hi = (a + 4 <= e);
               expq.push_back({1'b0, 1'b1, hi, hi, lo, lo, 32'(a)});
               a += 4;
            end
         end
      end
   endtask

   task automatic start_and_check();
      @(posedge clk); #2 run = 1'b1;
      @(posedge clk); @(negedge clk);
      check(busy && mreq && mdesc && maddr == tbl_al, "R1 start fetch",
            {busy, mreq, mdesc, maddr}, {3'b111, tbl_al});
   endtask

   task automatic run_table();
      start_and_check();
      while (busy) @(negedge clk);
      check(expq.size() == 0, "R7 stream complete at busy drop", expq.size(), 0);
      check(rgnq.size() == 0, "R4 all regions reported", rgnq.size(), 0);
      repeat (6) @(negedge clk);
      check(!busy && !mreq, "R7 stays idle with run high", {busy, mreq}, 0);
      @(posedge clk); #2 run = 1'b0;
      repeat (2) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !mreq && !rgn_load, "R1 reset state", {busy, mreq, rgn_load}, 0);

      // R9: stop in the middle of a 64 KiB read region.
      cnt_l[0] = 65536;
      load_table(1'b0, 0, 1, 32'h0008_0003);
      start_and_check();
      repeat (100) @(negedge clk);
      @(posedge clk); #2 run = 1'b0;
      @(posedge clk); @(negedge clk);
      check(!busy && !mreq, "R9 stop clears busy and request", {busy, mreq}, 0);
      expq.delete();
      rgnq.delete();
      repeat (5) @(negedge clk);
      check(!busy && !mreq, "R9 stays stopped", {busy, mreq}, 0);

      // Sweep of start offsets, both directions, eight regions per table.
      cnt_l[0] = 2;  cnt_l[1] = 4;  cnt_l[2] = 6;   cnt_l[3] = 64;
      cnt_l[4] = 66; cnt_l[5] = 62; cnt_l[6] = 130; cnt_l[7] = 8;
      for (int d = 0; d < 2; d++) begin
         for (int off = 0; off < 64; off += 2) begin
            load_table(d[0], off, 8, 32'h0008_0000 + 32'(off * 64) + 32'(off % 8));
            run_table();
         end
      end

      // R3: zero count field means 64 KiB, both directions.
      cnt_l[0] = 65536;
      load_table(1'b1, 2, 1, 32'h0009_0005);
      run_table();
      load_table(1'b0, 6, 1, 32'h0009_0100);
      run_table();

      finish_run();
   end
endmodule